// File: doc/BRIEF.md
# Serial Register Control Port

This block is the slave side of a four-wire serial control link. An external controller frames each access with an active-low select line, clocks bits in on a serial clock, and receives read data on a separate output line that the pad drives only while read data is moving. Each framed access carries a device select code, a direction bit, a register address and one data byte. The block turns these accesses into simple parallel register-bank cycles: an address, a write byte with a one-cycle write strobe, and a read byte that the bank returns combinationally for the presented address.

The serial pins are asynchronous to the block clock. They are resynchronised and the serial clock edges are detected in the block clock domain, so the block clock must run well above the serial clock (the link is limited to 5 MHz). A synchronous active-low reset holds the port idle: while it is asserted nothing is accepted and the read line stays released.

Top module: `ctl_port_top`

## Requirements
- R1: While `csn_i` is low, one bit of `cdti_i` is taken on each rising edge of `cclk_i`. The frame is 16 bits, MSB first in every field: bits 15..14 select code, bit 13 direction, bits 12..8 register address, bits 7..0 data.
- R2: A frame with select code 00 and direction bit 1 produces exactly one `reg_we_o` pulse of one clock cycle, with `reg_addr_o` equal to the address field and `reg_wdata_o` equal to the data field while the pulse is high.
- R3: A frame whose select code is not 00 is ignored: no write pulse, `cdto_oe_o` stays low and `reg_addr_o` keeps its previous value.
- R4: In a frame with select code 00 and direction bit 0, `cdto_o` presents `reg_rdata_i` for the address field MSB first; bit 7-k is updated after the falling `cclk_i` edge that follows rising edge 8+k (k = 0..7), so the controller takes it on rising edge 9+k.
- R5: `cdto_oe_o` is high only during the data phase of a read to select code 00: it rises after the falling edge after rising edge 8 and falls after the falling edge after rising edge 16 or when `csn_i` goes high.
- R6: A frame ended by `csn_i` rising before the 16th rising edge is discarded: no write pulse.
- R7: `csn_i` high clears the bit count, so the next frame is decoded from its first bit regardless of how the previous frame ended.
- R8: Rising edges after the 16th in the same frame are ignored: no second write pulse, and the read line is released.
- R9: While `rst_n` is low, no write pulse occurs, `cdto_oe_o` is low and `reg_addr_o` and `reg_wdata_o` are 0, whatever the serial pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csn_i | input | 1 | Serial frame select, active low, asynchronous |
| cclk_i | input | 1 | Serial bit clock, asynchronous |
| cdti_i | input | 1 | Serial data into the block |
| cdto_o | output | 1 | Serial read data, meaningful while `cdto_oe_o` is high |
| cdto_oe_o | output | 1 | Pad drive enable for the read line; low means high impedance |
| reg_addr_o | output | 5 | Register address toward the bank |
| reg_wdata_o | output | 8 | Write byte toward the bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read byte from the bank for `reg_addr_o` |

## Verification
The assertions take for granted that each high and low phase of the serial clock lasts several block clocks, longer than the synchroniser plus edge detector, that `csn_i` changes only while the serial clock is high, and that `cdti_i` is stable around each rising edge. The stimulus bit-bangs the link with ten block clocks per serial phase, changes data only while the serial clock is low, and moves the select line only with the serial clock high, while randomising select codes, directions, addresses, data and frame lengths (short, exact and over-long).

// File: rtl/ctl_port_pkg.sv
// Package: shared frame geometry for the serial register control port.
// Assumes the frame layout select code, direction, address, data, MSB first.
package ctl_port_pkg;
    localparam int SEL_W  = 2;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int HDR_W  = SEL_W + 1 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W  = $clog2(FRAME_W + 1);
endpackage

// File: rtl/ctl_port_sync.sv
// Module: multi-bit, multi-stage synchroniser for asynchronous pins.
// Each bit is resynchronised independently; per-bit reset value is a parameter.
// Assumes inputs are level signals held longer than STAGES clocks.
module ctl_port_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: one flop rank of the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctl_port_framer.sv
// Module: bit counter and frame decoder.
// Shifts serial bits on detected rising serial clock edges while select is low,
// decodes the header after HDR_W bits and the data after FRAME_W bits.
// Assumes synchronised select/data and a one-cycle rise pulse.
module ctl_port_framer
    import ctl_port_pkg::*;
#(
    parameter logic [SEL_W-1:0] DEV_SEL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              cdti_s,
    input  logic              rise,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              rd_mode_o,
    output logic              rd_load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              we_o
);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FRAME_FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] sh_nxt;
    logic [CNT_W-1:0]   cnt_q;
    logic               hdr_sel_ok;
    logic               frm_sel_ok;
    logic               frm_write;

    // Purpose: next shift value with the incoming bit at the LSB.
    always_comb begin
        sh_nxt     = {sh_q[FRAME_W-2:0], cdti_s};
        hdr_sel_ok = (sh_nxt[HDR_W-1 -: SEL_W] == DEV_SEL);
        frm_sel_ok = (sh_nxt[FRAME_W-1 -: SEL_W] == DEV_SEL);
        frm_write  = sh_nxt[FRAME_W-1-SEL_W];
    end

    // Purpose: count bits, capture header and data, emit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            addr_o    <= '0;
            wdata_o   <= '0;
            we_o      <= 1'b0;
            rd_mode_o <= 1'b0;
            rd_load_o <= 1'b0;
        end else begin
            we_o      <= 1'b0;
            rd_load_o <= 1'b0;
            if (csn_s) begin
                cnt_q     <= '0;
                rd_mode_o <= 1'b0;
            end else if (rise && cnt_q != FRAME_FULL) begin
                sh_q  <= sh_nxt;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == HDR_LAST && hdr_sel_ok) begin
                    addr_o    <= sh_nxt[ADDR_W-1:0];
                    rd_mode_o <= !sh_nxt[ADDR_W];
                    rd_load_o <= !sh_nxt[ADDR_W];
                end
                if (cnt_q == FRAME_LAST && frm_sel_ok && frm_write) begin
                    wdata_o <= sh_nxt[DATA_W-1:0];
                    we_o    <= 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;

    // R2: a write strobe never lasts more than one cycle.
    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o);
    // R6: a write strobe appears only once the full frame has been counted.
    a_r6_we_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_o) |-> (cnt_q == FRAME_FULL));
    // R8: the bit count never runs past the frame length.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FRAME_FULL);
    // R7: select high always brings the count back to zero.
    a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (cnt_q == '0));
endmodule

// File: rtl/ctl_port_rdout.sv
// Module: read data serialiser and pad enable.
// Loads the bank byte after a read header, drives it MSB first,
// advancing on falling serial clock edges during the data phase.
// Assumes the bank returns data combinationally one cycle after the address.
module ctl_port_rdout
    import ctl_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              fall,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              rd_mode_i,
    input  logic              rd_load_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              dout_o,
    output logic              oe_o
);
    localparam logic [CNT_W-1:0] DATA_START = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] FRAME_FULL = CNT_W'(FRAME_W);

    logic [DATA_W-1:0] obuf_q;

    // Purpose: load, shift and enable the read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obuf_q <= '0;
            oe_o   <= 1'b0;
        end else if (csn_s || !rd_mode_i) begin
            oe_o <= 1'b0;
        end else begin
            if (rd_load_i) obuf_q <= rdata_i;
            if (fall) begin
                if (cnt_i == DATA_START) oe_o <= 1'b1;
                else if (cnt_i == FRAME_FULL) oe_o <= 1'b0;
                else if (oe_o) obuf_q <= {obuf_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign dout_o = oe_o & obuf_q[DATA_W-1];

    // R5: the pad is driven only inside a read frame.
    a_r5_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> rd_mode_i);
    // R5: select high releases the pad on the next cycle.
    a_r5_oe_off_csn: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !oe_o);
    // R4: driving starts exactly when the header has been counted.
    a_r4_oe_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> (cnt_i == DATA_START));
endmodule

// File: rtl/ctl_port_top.sv
// Module: serial register control port, top level.
// Resynchronises the four-wire link, detects serial clock edges and
// connects frame decoding and read serialisation to the register bank.
// Assumes clk runs many times faster than cclk_i.
module ctl_port_top
    import ctl_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [SEL_W-1:0] DEV_SEL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              cclk_i,
    input  logic              cdti_i,
    output logic              cdto_o,
    output logic              cdto_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    logic [2:0]       pins_s;
    logic             csn_s, cclk_s, cdti_s, cclk_d;
    logic             rise, fall;
    logic [CNT_W-1:0] cnt;
    logic             rd_mode, rd_load;

    // Bit order: {csn, cclk, cdti}; select and clock idle high.
    ctl_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({csn_i, cclk_i, cdti_i}),
        .q_o   (pins_s)
    );
    assign {csn_s, cclk_s, cdti_s} = pins_s;

    // Purpose: delay the synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cclk_d <= 1'b1;
        else cclk_d <= cclk_s;
    end

    assign rise = cclk_s & ~cclk_d;
    assign fall = ~cclk_s & cclk_d;

    ctl_port_framer #(.DEV_SEL(DEV_SEL)) framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (csn_s),
        .cdti_s    (cdti_s),
        .rise      (rise),
        .cnt_o     (cnt),
        .rd_mode_o (rd_mode),
        .rd_load_o (rd_load),
        .addr_o    (reg_addr_o),
        .wdata_o   (reg_wdata_o),
        .we_o      (reg_we_o)
    );

    ctl_port_rdout rdout_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (csn_s),
        .fall      (fall),
        .cnt_i     (cnt),
        .rd_mode_i (rd_mode),
        .rd_load_i (rd_load),
        .rdata_i   (reg_rdata_i),
        .dout_o    (cdto_o),
        .oe_o      (cdto_oe_o)
    );
endmodule

// File: tb/ctl_port_top_tb_top.sv
// Bench: bit-bangs the serial link against a bench register bank and
// compares strobes, written values, read bits and pad enable with a model.
module ctl_port_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csn = 1'b1, cclk = 1'b1, cdti = 1'b0;
    logic       cdto, cdto_oe;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_we;

    int n_chk = 0, n_bad = 0, strobes = 0;
    logic [4:0] last_waddr = '0;
    logic [7:0] last_wdata = '0;
    logic [7:0] bank [32];
    logic [7:0] exp_bank [32];

    always #5 clk = ~clk;

    ctl_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .cclk_i(cclk), .cdti_i(cdti),
        .cdto_o(cdto), .cdto_oe_o(cdto_oe), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 37 + 5);
    endfunction

    // Model: does a frame of this length and content strobe a write?
    function automatic bit exp_write(input logic [15:0] w, input int len);
        return (len >= 16) && (w[15:14] == 2'b00) && w[13];
    endfunction

    function automatic bit exp_read(input logic [15:0] w);
        return (w[15:14] == 2'b00) && !w[13];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bank model in the bench: a write strobe updates the stored byte.
    always @(negedge clk) begin
        if (reg_we) begin
            strobes++;
            last_waddr = reg_addr;
            last_wdata = reg_wdata;
            bank[reg_addr] = reg_wdata;
        end
    end

    // Sends len bits (word MSB first, then random extras); samples the read
    // line before every rising edge. drv_exp: read data phase expected.
    task automatic xfer(input logic [15:0] word, input int len, input bit drv_exp,
                        output logic [7:0] rd, output int oe_bad);
        rd = '0;
        oe_bad = 0;
        @(negedge clk);
        csn = 1'b0;
        repeat (10) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            cclk = 1'b0;
            cdti = (k < 16) ? word[15-k] : 1'($urandom_range(0, 1));
            repeat (10) @(negedge clk);
            if (cdto_oe !== ((drv_exp && k >= 8 && k < 16) ? 1'b1 : 1'b0)) oe_bad++;
            if (k >= 8 && k < 16) rd[15-k] = cdto;
            cclk = 1'b1;
            repeat (10) @(negedge clk);
        end
        csn = 1'b1;
        repeat (20) @(negedge clk);
        if (cdto_oe !== 1'b0) oe_bad++;
    endtask

    task automatic run_frame(input logic [15:0] w, input int len, input string tag);
        int s0, oe_bad;
        logic [7:0] rd;
        logic [4:0] a0;
        bit wr, rdm;
        s0 = strobes;
        a0 = reg_addr;
        wr = exp_write(w, len);
        rdm = exp_read(w) && rst_n;
        xfer(w, len, rdm && len > 8, rd, oe_bad);
        if (!rst_n) wr = 1'b0;
        chk({tag, " R2/R6 strobe count"}, strobes - s0, wr ? 1 : 0);
        chk({tag, " R5 pad enable"}, oe_bad, 0);
        if (wr) begin
            exp_bank[w[12:8]] = w[7:0];
            chk({tag, " R1 write address"}, last_waddr, w[12:8]);
            chk({tag, " R2 write data"}, last_wdata, w[7:0]);
        end
        if (rdm && len >= 16)
            chk({tag, " R4 read data"}, rd, exp_bank[w[12:8]]);
        if (w[15:14] != 2'b00 || !rst_n)
            chk({tag, " R3 address held"}, reg_addr, rst_n ? a0 : 5'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            bank[i] = init_val(i);
            exp_bank[i] = init_val(i);
        end
        void'($urandom(32'd1234));
        // R9: frames during reset are ignored.
        repeat (5) @(negedge clk);
        run_frame(16'h2A5C, 16, "R9 reset write");
        run_frame(16'h0300, 16, "R9 reset read");
        chk("R9 reset wdata", reg_wdata, 8'h00);
        chk("R9 reset we", reg_we, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // Directed cases.
        run_frame({2'b00, 1'b1, 5'd31, 8'hC3}, 16, "R2 write top address");
        run_frame({2'b00, 1'b0, 5'd31, 8'h00}, 16, "R4 read back");
        run_frame({2'b00, 1'b1, 5'd0, 8'h81}, 16, "R1 write address 0");
        run_frame({2'b00, 1'b0, 5'd0, 8'h00}, 16, "R4 read address 0");
        run_frame({2'b10, 1'b1, 5'd3, 8'hFF}, 16, "R3 foreign select write");
        run_frame({2'b01, 1'b0, 5'd3, 8'h00}, 16, "R3 foreign select read");
        run_frame({2'b00, 1'b1, 5'd4, 8'h77}, 15, "R6 short by one");
        run_frame({2'b00, 1'b1, 5'd4, 8'h55}, 16, "R7 fresh frame after short");
        run_frame({2'b00, 1'b1, 5'd5, 8'h3C}, 20, "R8 long write");
        run_frame({2'b00, 1'b0, 5'd5, 8'h00}, 19, "R8 long read");
        run_frame({2'b00, 1'b0, 5'd6, 8'h00}, 5, "R7 short read header");
        run_frame({2'b00, 1'b0, 5'd4, 8'h00}, 16, "R7 read after short");
        // Constrained random frames.
        for (int n = 0; n < 160; n++) begin
            logic [15:0] w;
            int len, p;
            w[15:14] = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            w[13]    = 1'($urandom_range(0, 1));
            w[12:8]  = 5'($urandom_range(0, 31));
            w[7:0]   = 8'($urandom_range(0, 255));
            p = $urandom_range(0, 9);
            len = (p == 0) ? $urandom_range(1, 15) : (p == 1) ? $urandom_range(17, 20) : 16;
            run_frame(w, len, "R1 random");
        end
        // Final sweep: every register matches the model.
        for (int a = 0; a < 32; a++)
            run_frame({2'b00, 1'b0, 5'(a), 8'h00}, 16, "R4 sweep");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule